// File: doc/BRIEF.md
# Flash Cycle Sequencer

This block lets software run a complete flash read, page program or block erase by filling a few registers. Software loads a 24-bit flash address, fills a 64-byte data buffer when it wants to program, and writes the control register. That write carries the cycle type, the byte count and the start bit. The engine then builds the flash commands, using the standard read, program, erase, write-enable and read-status opcodes. It hands each byte to a byte-serial SPI master through a request/acknowledge handshake and frames each command with an active-low chip select.

The status register shows progress and results. A cycle-in-progress flag rejects new work. Done, error and access-error are sticky flags that software clears by writing 1. A lock-down flag stays set until reset. For program and erase cycles, the engine sends a write-enable command first. After the main command it keeps reading the flash status byte until the busy bit is clear, and only then reports done.

Top module: `flash_seq_engine`

## Requirements
- R1: After reset, the control, status and address registers read 0.
- R2: Writing the control register with bit 0 (GO) set while the status in-progress bit (bit 5) is clear starts a cycle. Bit 5 reads 1 from the next cycle until the cycle ends. GO reads back 0 once the cycle is accepted.
- R3: Read cycle (control bits [2:1] = 0) sends one frame. The frame is opcode 0x03, then the three address bytes most significant first, then N filler bytes of 0x00. The N returned bytes go into buffer bytes 0..N-1. Buffer byte i is bits [8*(i%4)+7 : 8*(i%4)] of buffer word i/4, and buffer word w sits at host address 16+w.
- R4: Program cycle (type 2) sends a frame holding only 0x06. It then sends a frame of 0x02, the three address bytes and buffer bytes 0..N-1, followed by status polling.
- R5: Erase cycle (type 3) sends a frame holding only 0x06. It then sends a frame of 0x20 and the three address bytes, with no data bytes and no regard to the byte count, followed by status polling.
- R6: Polling repeats a two-byte frame (0x05, filler). It stops on the first returned byte whose bit 0 is 0, whatever its other bits. Status bit 0 (done) is set on the same edge that clears bit 5.
- R7: Control bits [13:8] hold N-1, so one cycle moves 1 to 64 bytes. Buffer bytes at or above N are left untouched by a read.
- R8: Status bits 0 (done), 1 (error) and 2 (access error) each clear only when a 1 is written to that bit. Writing 0 leaves them as they are.
- R9: While bit 5 is set, writes to the control register, the address register (host address 2) and the buffer are ignored. This includes a second GO.
- R10: A GO with the reserved type 1 sets error and access error, leaves done clear and sends no frame.
- R11: Writing 1 to status bit 15 sets the lock-down flag. Nothing clears it except reset.
- R12: A byte request stays asserted, with its byte value held, until it is acknowledged. Chip select rises between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 5 | Word address: 0 control, 1 status, 2 flash address, 16..31 buffer |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for host_addr (combinational) |
| spi_cs_n | output | 1 | Active-low frame select to the serializer |
| spi_req | output | 1 | Byte request to the serializer |
| spi_tx_byte | output | 8 | Byte to shift out |
| spi_ack | input | 1 | One-cycle acknowledge that the byte was exchanged |
| spi_rx_byte | input | 8 | Byte shifted in, valid with spi_ack |

## Verification
The in-progress flag is due on the edge that captures the GO write, so the bench reads it at the falling edge right after its write task. The error flags of a reserved-type start are due one edge later, on acceptance. Done and the cleared in-progress flag are due on the edge that takes the final acknowledge, which is why the bench waits by polling the in-progress bit at falling edges instead of counting a fixed number of cycles. The bench captures frame contents byte by byte on the acknowledge handshake, with serializer latencies of 0 to 2 cycles. Register and buffer readbacks are taken only after the cycle has finished.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        CYC_READ  = 2'd0,
        CYC_RSVD  = 2'd1,
        CYC_PROG  = 2'd2,
        CYC_ERASE = 2'd3
    } cyc_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WREN,
        S_GAP_A,
        S_OPC,
        S_ADR,
        S_DAT,
        S_GAP_B,
        S_POLL_OP,
        S_POLL_RD
    } seq_state_e;

    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam logic [7:0] OPC_PROG  = 8'h02;
    localparam logic [7:0] OPC_ERASE = 8'h20;
    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_RDSR  = 8'h05;
    localparam logic [7:0] FILL_BYTE = 8'h00;

    localparam int CTRL_CNT_LSB = 8;
    localparam int ST_DONE = 0;
    localparam int ST_ERR  = 1;
    localparam int ST_AEL  = 2;
    localparam int ST_SCIP = 5;
    localparam int ST_LOCK = 15;

endpackage

// File: rtl/fseq_buffer.sv
module fseq_buffer #(
    parameter int WORDS = 16,
    parameter int CNT_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     h_we,
    input  logic [$clog2(WORDS)-1:0] h_word,
    input  logic [31:0]              h_wdata,
    output logic [31:0]              h_rdata,
    input  logic                     e_we,
    input  logic [CNT_W-1:0]         e_idx,
    input  logic [7:0]               e_wdata,
    output logic [7:0]               e_rdata
);
    localparam int WIDX_W = $clog2(WORDS);

    logic [31:0] mem_q [WORDS];
    logic [31:0] mem_d [WORDS];

    logic [WIDX_W-1:0] e_word;
    logic [1:0]        e_lane;

    assign e_word = e_idx[CNT_W-1:2];
    assign e_lane = e_idx[1:0];

    always_comb begin
        for (int w = 0; w < WORDS; w++) begin
            mem_d[w] = mem_q[w];
        end
        if (h_we) begin
            mem_d[h_word] = h_wdata;
        end
        if (e_we) begin
            mem_d[e_word][8*e_lane +: 8] = e_wdata;
        end
        h_rdata = mem_q[h_word];
        e_rdata = mem_q[e_word][8*e_lane +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) begin
                mem_q[w] <= '0;
            end
        end else begin
            for (int w = 0; w < WORDS; w++) begin
                mem_q[w] <= mem_d[w];
            end
        end
    end
endmodule

// File: rtl/fseq_csr.sv
module fseq_csr
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl_i,
    input  logic              wr_stat_i,
    input  logic              wr_addr_i,
    input  logic [ADDR_W-1:0] wdata_i,
    input  logic              seq_accept_i,
    input  logic              seq_busy_i,
    input  logic              seq_done_i,
    input  logic              seq_fault_i,
    output logic              go_o,
    output cyc_e              cyc_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [ADDR_W-1:0] faddr_o,
    output logic              scip_o,
    output logic [15:0]       ctrl_rd_o,
    output logic [15:0]       stat_rd_o
);
    typedef struct packed {
        logic              go;
        cyc_e              cyc;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] faddr;
        logic              done;
        logic              err;
        logic              ael;
        logic              lock;
    } csr_t;

    csr_t q, d;
    logic scip;

    always_comb begin
        d    = q;
        scip = q.go | seq_busy_i;

        if (wr_ctrl_i && !scip) begin
            d.go  = wdata_i[0];
            d.cyc = cyc_e'(wdata_i[2:1]);
            d.cnt = wdata_i[CTRL_CNT_LSB +: CNT_W];
        end
        if (wr_addr_i && !scip) begin
            d.faddr = wdata_i;
        end
        if (seq_accept_i) begin
            d.go = 1'b0;
        end

        if (wr_stat_i) begin
            if (wdata_i[ST_DONE]) d.done = 1'b0;
            if (wdata_i[ST_ERR])  d.err  = 1'b0;
            if (wdata_i[ST_AEL])  d.ael  = 1'b0;
            if (wdata_i[ST_LOCK]) d.lock = 1'b1;
        end
        if (seq_done_i) begin
            d.done = 1'b1;
        end
        if (seq_fault_i) begin
            d.err = 1'b1;
            d.ael = 1'b1;
        end

        ctrl_rd_o                          = '0;
        ctrl_rd_o[0]                       = q.go;
        ctrl_rd_o[2:1]                     = q.cyc;
        ctrl_rd_o[CTRL_CNT_LSB +: CNT_W]   = q.cnt;

        stat_rd_o          = '0;
        stat_rd_o[ST_DONE] = q.done;
        stat_rd_o[ST_ERR]  = q.err;
        stat_rd_o[ST_AEL]  = q.ael;
        stat_rd_o[ST_SCIP] = scip;
        stat_rd_o[ST_LOCK] = q.lock;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{go: 1'b0, cyc: CYC_READ, cnt: '0, faddr: '0,
                   done: 1'b0, err: 1'b0, ael: 1'b0, lock: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign go_o    = q.go;
    assign cyc_o   = q.cyc;
    assign cnt_o   = q.cnt;
    assign faddr_o = q.faddr;
    assign scip_o  = scip;
endmodule

// File: rtl/fseq_sequencer.sv
module fseq_sequencer
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  cyc_e              cyc_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wbyte_i,
    input  logic              spi_ack_i,
    input  logic [7:0]        spi_rx_i,
    output logic              accept_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              fault_o,
    output logic              spi_req_o,
    output logic              spi_cs_n_o,
    output logic [7:0]        spi_tx_o,
    output logic              bwr_o,
    output logic [CNT_W-1:0]  bidx_o,
    output logic [7:0]        bwdata_o
);
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam logic [CNT_W-1:0] LAST_ADR = CNT_W'(ADDR_BYTES - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  idx;
        logic [ADDR_W-1:0] ashift;
    } seq_t;

    seq_t q, d;

    function automatic logic [7:0] main_opcode(cyc_e c);
        case (c)
            CYC_PROG:  return OPC_PROG;
            CYC_ERASE: return OPC_ERASE;
            default:   return OPC_READ;
        endcase
    endfunction

    always_comb begin
        d         = q;
        accept_o  = 1'b0;
        done_o    = 1'b0;
        fault_o   = 1'b0;
        spi_req_o = 1'b0;
        spi_tx_o  = FILL_BYTE;
        bwr_o     = 1'b0;

        case (q.state)
            S_IDLE: begin
                if (go_i) begin
                    accept_o = 1'b1;
                    d.idx    = '0;
                    d.ashift = addr_i;
                    case (cyc_i)
                        CYC_READ:            d.state = S_OPC;
                        CYC_PROG, CYC_ERASE: d.state = S_WREN;
                        default:             fault_o = 1'b1;
                    endcase
                end
            end
            S_WREN: begin
                spi_req_o = 1'b1;
                spi_tx_o  = OPC_WREN;
                if (spi_ack_i) d.state = S_GAP_A;
            end
            S_GAP_A: begin
                d.state = S_OPC;
            end
            S_OPC: begin
                spi_req_o = 1'b1;
                spi_tx_o  = main_opcode(cyc_i);
                if (spi_ack_i) begin
                    d.state = S_ADR;
                    d.idx   = '0;
                end
            end
            S_ADR: begin
                spi_req_o = 1'b1;
                spi_tx_o  = q.ashift[ADDR_W-1 -: 8];
                if (spi_ack_i) begin
                    d.ashift = q.ashift << 8;
                    if (q.idx == LAST_ADR) begin
                        d.idx   = '0;
                        d.state = (cyc_i == CYC_ERASE) ? S_GAP_B : S_DAT;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            S_DAT: begin
                spi_req_o = 1'b1;
                spi_tx_o  = (cyc_i == CYC_READ) ? FILL_BYTE : wbyte_i;
                if (spi_ack_i) begin
                    bwr_o = (cyc_i == CYC_READ);
                    if (q.idx == cnt_i) begin
                        if (cyc_i == CYC_READ) begin
                            done_o  = 1'b1;
                            d.state = S_IDLE;
                        end else begin
                            d.state = S_GAP_B;
                        end
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            S_GAP_B: begin
                d.state = S_POLL_OP;
            end
            S_POLL_OP: begin
                spi_req_o = 1'b1;
                spi_tx_o  = OPC_RDSR;
                if (spi_ack_i) d.state = S_POLL_RD;
            end
            S_POLL_RD: begin
                spi_req_o = 1'b1;
                spi_tx_o  = FILL_BYTE;
                if (spi_ack_i) begin
                    if (spi_rx_i[0]) begin
                        d.state = S_GAP_B;
                    end else begin
                        done_o  = 1'b1;
                        d.state = S_IDLE;
                    end
                end
            end
            default: begin
                d.state = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: S_IDLE, idx: '0, ashift: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o     = (q.state != S_IDLE);
    assign spi_cs_n_o = ~spi_req_o;
    assign bidx_o     = q.idx;
    assign bwdata_o   = spi_rx_i;
endmodule

// File: rtl/flash_seq_engine.sv
module flash_seq_engine
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int BUF_WORDS = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               host_we,
    input  logic [$clog2(BUF_WORDS):0]         host_addr,
    input  logic [31:0]                        host_wdata,
    output logic [31:0]                        host_rdata,
    output logic                               spi_cs_n,
    output logic                               spi_req,
    output logic [7:0]                         spi_tx_byte,
    input  logic                               spi_ack,
    input  logic [7:0]                         spi_rx_byte
);
    localparam int BUF_BYTES = BUF_WORDS * 4;
    localparam int CNT_W     = $clog2(BUF_BYTES);
    localparam int WIDX_W    = $clog2(BUF_WORDS);
    localparam int HADDR_W   = WIDX_W + 1;
    localparam logic [HADDR_W-1:0] REG_CTRL  = HADDR_W'(0);
    localparam logic [HADDR_W-1:0] REG_STAT  = HADDR_W'(1);
    localparam logic [HADDR_W-1:0] REG_FADDR = HADDR_W'(2);

    logic              buf_sel;
    logic              wr_ctrl, wr_stat, wr_addr, wr_buf;
    logic              go, scip;
    cyc_e              cyc;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] faddr;
    logic [15:0]       ctrl_word, stat_word;
    logic              seq_accept, seq_busy, seq_done, seq_fault;
    logic              b_we;
    logic [CNT_W-1:0]  b_idx;
    logic [7:0]        b_wdata, b_rdata;
    logic [31:0]       buf_hrdata;
    logic              lock_flag, done_flag;

    assign buf_sel = host_addr[HADDR_W-1];
    assign wr_ctrl = host_we && !buf_sel && (host_addr == REG_CTRL);
    assign wr_stat = host_we && !buf_sel && (host_addr == REG_STAT);
    assign wr_addr = host_we && !buf_sel && (host_addr == REG_FADDR);
    assign wr_buf  = host_we && buf_sel && !scip;

    fseq_csr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_csr (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_ctrl_i    (wr_ctrl),
        .wr_stat_i    (wr_stat),
        .wr_addr_i    (wr_addr),
        .wdata_i      (host_wdata[ADDR_W-1:0]),
        .seq_accept_i (seq_accept),
        .seq_busy_i   (seq_busy),
        .seq_done_i   (seq_done),
        .seq_fault_i  (seq_fault),
        .go_o         (go),
        .cyc_o        (cyc),
        .cnt_o        (cnt),
        .faddr_o      (faddr),
        .scip_o       (scip),
        .ctrl_rd_o    (ctrl_word),
        .stat_rd_o    (stat_word)
    );

    fseq_sequencer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (go),
        .cyc_i      (cyc),
        .cnt_i      (cnt),
        .addr_i     (faddr),
        .wbyte_i    (b_rdata),
        .spi_ack_i  (spi_ack),
        .spi_rx_i   (spi_rx_byte),
        .accept_o   (seq_accept),
        .busy_o     (seq_busy),
        .done_o     (seq_done),
        .fault_o    (seq_fault),
        .spi_req_o  (spi_req),
        .spi_cs_n_o (spi_cs_n),
        .spi_tx_o   (spi_tx_byte),
        .bwr_o      (b_we),
        .bidx_o     (b_idx),
        .bwdata_o   (b_wdata)
    );

    fseq_buffer #(.WORDS(BUF_WORDS), .CNT_W(CNT_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .h_we    (wr_buf),
        .h_word  (host_addr[WIDX_W-1:0]),
        .h_wdata (host_wdata),
        .h_rdata (buf_hrdata),
        .e_we    (b_we),
        .e_idx   (b_idx),
        .e_wdata (b_wdata),
        .e_rdata (b_rdata)
    );

    always_comb begin
        host_rdata = '0;
        if (buf_sel) begin
            host_rdata = buf_hrdata;
        end else if (host_addr == REG_CTRL) begin
            host_rdata = {16'h0, ctrl_word};
        end else if (host_addr == REG_STAT) begin
            host_rdata = {16'h0, stat_word};
        end else if (host_addr == REG_FADDR) begin
            host_rdata = 32'(faddr);
        end
    end

    assign lock_flag = stat_word[ST_LOCK];
    assign done_flag = stat_word[ST_DONE];
endmodule

// File: rtl/fseq_checker.sv
module fseq_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_req,
    input logic              spi_ack,
    input logic [7:0]        spi_tx_byte,
    input logic              lock,
    input logic              done,
    input logic              scip,
    input logic              go,
    input logic              seq_busy,
    input logic [ADDR_W-1:0] faddr
);
    // R2
    go_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !seq_busy) |=> !go);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !seq_busy);

    // R9
    addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(scip) |-> $stable(faddr));

    // R11
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_req && !spi_ack) |=> (spi_req && $stable(spi_tx_byte)));
endmodule

bind flash_seq_engine fseq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_req     (spi_req),
    .spi_ack     (spi_ack),
    .spi_tx_byte (spi_tx_byte),
    .lock        (lock_flag),
    .done        (done_flag),
    .scip        (scip),
    .go          (go),
    .seq_busy    (seq_busy),
    .faddr       (faddr)
);

// File: tb/flash_seq_engine_tb.sv
module flash_seq_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        spi_cs_n, spi_req;
    logic [7:0]  spi_tx_byte;
    logic        spi_ack = 1'b0;
    logic [7:0]  spi_rx_byte = '0;

    always #10 clk = ~clk;

    flash_seq_engine u_dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .spi_cs_n(spi_cs_n),
        .spi_req(spi_req), .spi_tx_byte(spi_tx_byte), .spi_ack(spi_ack),
        .spi_rx_byte(spi_rx_byte)
    );

    int n_chk = 0;
    int n_fail = 0;

    // serializer / flash model state
    logic [7:0]  lb_byte [512];
    int          lb_frame [512];
    int          lb_n = 0;
    int          fr_n = 0;
    bit          in_fr = 0;
    int          pos = 0;
    logic [7:0]  cur_op = '0;
    logic [23:0] cur_a = '0;
    int          lat = 0;
    int          busy_left = 0;

    // expected stream
    logic [7:0]  ex_b [512];
    int          ex_f [512];
    int          ex_n = 0;
    int          ef_n = 0;

    function automatic logic [7:0] pat(logic [23:0] a);
        logic [7:0] m;
        m = a[7:0] * 8'd37;
        return m + a[15:8] + a[23:16] + 8'h5A;
    endfunction

    function automatic logic [7:0] wb(int seed, int i);
        return 8'(seed * 3 + i * 11 + 1);
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            spi_ack = 1'b0;
            if (spi_cs_n) in_fr = 0;
            if (spi_req) begin
                logic [7:0] b;
                logic [7:0] rx;
                if (!in_fr) begin
                    in_fr = 1;
                    fr_n++;
                    pos = 0;
                end
                b = spi_tx_byte;
                if (lb_n < 512) begin
                    lb_byte[lb_n]  = b;
                    lb_frame[lb_n] = fr_n;
                end
                lb_n++;
                if (pos == 0) cur_op = b;
                else if (pos <= 3) cur_a = {cur_a[15:0], b};
                rx = 8'h00;
                if (cur_op == 8'h03 && pos >= 4) begin
                    rx = pat(cur_a + 24'(pos - 4));
                end else if (cur_op == 8'h05 && pos == 1) begin
                    rx = (busy_left > 0) ? 8'h03 : 8'h02;
                    if (busy_left > 0) busy_left--;
                end
                pos++;
                repeat (lat) @(negedge clk);
                spi_ack = 1'b1;
                spi_rx_byte = rx;
            end
        end
    end

    task automatic hwr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1;
        host_addr = a;
        host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hrd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic wait_idle(string req);
        logic [31:0] s;
        int n;
        n = 0;
        do begin
            hrd(5'd1, s);
            n++;
        end while (s[5] && n < 20000);
        check(req, "in-progress clears", 32'(s[5]), 32'd0);
    endtask

    task automatic clear_log();
        lb_n = 0; fr_n = 0; ex_n = 0; ef_n = 0;
    endtask

    task automatic ex_frame();
        ef_n++;
    endtask

    task automatic ex_byte(input logic [7:0] b);
        ex_b[ex_n] = b;
        ex_f[ex_n] = ef_n;
        ex_n++;
    endtask

    task automatic ex_addr(input logic [23:0] a);
        ex_byte(a[23:16]); ex_byte(a[15:8]); ex_byte(a[7:0]);
    endtask

    task automatic ex_polls(input int busy);
        for (int p = 0; p <= busy; p++) begin
            ex_frame(); ex_byte(8'h05); ex_byte(8'h00);
        end
    endtask

    task automatic cmp_stream(string req);
        int mism;
        mism = 0;
        check(req, "byte total", 32'(lb_n), 32'(ex_n));
        // R12: frames are counted on chip-select rising between them
        check(req, "frame total", 32'(fr_n), 32'(ef_n));
        for (int i = 0; i < ex_n && i < lb_n; i++) begin
            if (lb_byte[i] !== ex_b[i] || lb_frame[i] != ex_f[i]) begin
                if (mism == 0)
                    $display("  first stream difference at byte %0d: %h/f%0d vs %h/f%0d",
                             i, lb_byte[i], lb_frame[i], ex_b[i], ex_f[i]);
                mism++;
            end
        end
        check(req, "stream mismatches", 32'(mism), 32'd0);
    endtask

    task automatic fill_buf(input logic [31:0] v);
        for (int w = 0; w < 16; w++) hwr(5'(16 + w), v);
    endtask

    initial begin
        logic [31:0] r;
        int rc [8] = '{0, 1, 2, 3, 4, 7, 31, 63};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1
        hrd(5'd0, r); check("R1", "control", r, 32'h0);
        hrd(5'd1, r); check("R1", "status", r, 32'h0);
        hrd(5'd2, r); check("R1", "address", r, 32'h0);

        // read sweep
        for (int k = 0; k < 8; k++) begin
            logic [23:0] a;
            int mism;
            a = 24'h123456 + 24'(k) * 24'h0F0F1;
            lat = k % 3;
            fill_buf(32'hCCCCCCCC);
            hwr(5'd2, 32'(a));
            clear_log();
            hwr(5'd0, (32'(rc[k]) << 8) | 32'h1);
            hrd(5'd1, r); check("R2", "in-progress after GO", 32'(r[5]), 32'd1);
            wait_idle("R2");
            hrd(5'd0, r); check("R2", "GO cleared, fields kept", r, 32'(rc[k]) << 8);
            hrd(5'd1, r); check("R3", "status done", r, 32'h1);
            ex_frame(); ex_byte(8'h03); ex_addr(a);
            for (int i = 0; i <= rc[k]; i++) ex_byte(8'h00);
            cmp_stream("R3");
            mism = 0;
            for (int w = 0; w < 16; w++) begin
                hrd(5'(16 + w), r);
                for (int j = 0; j < 4; j++) begin
                    int i;
                    logic [7:0] e;
                    i = 4 * w + j;
                    e = (i <= rc[k]) ? pat(a + 24'(i)) : 8'hCC;
                    if (r[8*j +: 8] !== e) mism++;
                end
            end
            check("R7", "buffer bytes after read", 32'(mism), 32'd0);
            hwr(5'd1, 32'h0);
            hrd(5'd1, r); check("R8", "write 0 keeps done", r, 32'h1);
            hwr(5'd1, 32'h1);
            hrd(5'd1, r); check("R8", "write 1 clears done", r, 32'h0);
        end

        // program sweep
        begin
            int pc [4] = '{0, 5, 62, 63};
            int pb [4] = '{0, 1, 3, 2};
            for (int k = 0; k < 4; k++) begin
                logic [23:0] a;
                a = 24'hF00000 + 24'(k) * 24'h1357;
                lat = (k + 1) % 3;
                for (int w = 0; w < 16; w++)
                    hwr(5'(16 + w), {wb(k, 4*w+3), wb(k, 4*w+2), wb(k, 4*w+1), wb(k, 4*w)});
                hwr(5'd2, 32'(a));
                busy_left = pb[k];
                clear_log();
                hwr(5'd0, (32'(pc[k]) << 8) | 32'h5);
                wait_idle("R4");
                hrd(5'd1, r); check("R6", "done after polling", r, 32'h1);
                ex_frame(); ex_byte(8'h06);
                ex_frame(); ex_byte(8'h02); ex_addr(a);
                for (int i = 0; i <= pc[k]; i++) ex_byte(wb(k, i));
                ex_polls(pb[k]);
                cmp_stream("R4");
                hwr(5'd1, 32'h1);
            end
        end

        // erase
        lat = 1;
        busy_left = 2;
        hwr(5'd2, 32'h00ABCD);
        clear_log();
        hwr(5'd0, 32'h0000_2507);
        wait_idle("R5");
        hrd(5'd1, r); check("R5", "done after erase", r, 32'h1);
        ex_frame(); ex_byte(8'h06);
        ex_frame(); ex_byte(8'h20); ex_addr(24'h00ABCD);
        ex_polls(2);
        cmp_stream("R5");
        hwr(5'd1, 32'h1);

        // writes while busy are ignored
        lat = 2;
        fill_buf(32'hCCCCCCCC);
        hwr(5'd2, 32'h345678);
        clear_log();
        hwr(5'd0, 32'h0000_3F01);
        hwr(5'd0, 32'h0000_0007);
        hwr(5'd2, 32'h00ABCDEF);
        hwr(5'd16, 32'h11223344);
        wait_idle("R9");
        repeat (5) @(negedge clk);
        hrd(5'd1, r); check("R9", "no second cycle", r, 32'h1);
        hrd(5'd0, r); check("R9", "control unchanged", r, 32'h0000_3F00);
        hrd(5'd2, r); check("R9", "address unchanged", r, 32'h345678);
        hrd(5'd16, r);
        check("R9", "buffer word 0 from flash",
              r, {pat(24'h34567B), pat(24'h34567A), pat(24'h345679), pat(24'h345678)});
        ex_frame(); ex_byte(8'h03); ex_addr(24'h345678);
        for (int i = 0; i < 64; i++) ex_byte(8'h00);
        cmp_stream("R9");
        hwr(5'd1, 32'h1);

        // reserved type
        clear_log();
        hwr(5'd0, 32'h0000_0003);
        wait_idle("R10");
        hrd(5'd1, r); check("R10", "error and access error", r, 32'h6);
        check("R10", "no bytes sent", 32'(lb_n), 32'd0);
        hwr(5'd1, 32'h2);
        hrd(5'd1, r); check("R8", "clear error only", r, 32'h4);
        hwr(5'd1, 32'h4);
        hrd(5'd1, r); check("R8", "clear access error", r, 32'h0);

        // lock-down
        hwr(5'd1, 32'h8000);
        hrd(5'd1, r); check("R11", "lock set", r, 32'h8000);
        hwr(5'd1, 32'h0000);
        hrd(5'd1, r); check("R11", "lock kept on 0", r, 32'h8000);
        lat = 0;
        clear_log();
        hwr(5'd0, 32'h0000_0001);
        wait_idle("R11");
        hrd(5'd1, r); check("R11", "lock kept across cycle", r, 32'h8001);
        hwr(5'd1, 32'h0000_0007);
        hrd(5'd1, r); check("R11", "lock kept on clears", r, 32'h8000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog: actual still running, expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule